// File: doc/BRIEF.md
# Maximum-Magnitude Index Selector

This block takes a stream of signed correlation values and returns the position of the entry with the largest absolute value. That position is the column a greedy sparse-recovery loop adds to its support on each iteration. A vector arrives as one or more wide beats of `LANES` elements. Each beat is split into `GROUPS` equal groups. Every group is reduced by its own pruned comparison tree, which keeps only the winning value and its lane and records no ordering. The group winners are registered. A second comparison tree then reduces them to one winner for the beat. A running winner register compares each beat winner with the best value seen so far in the vector.

When the beat flagged as last has passed both stages, the block presents the winning global index and its magnitude. The result is held until the consumer accepts it. A `start` pulse clears any partial vector and any pending result. The running winner and the beat count also clear by themselves after each last beat, so vectors can follow one another without a pulse in between.

Top module: `maxmag_picker`

## Requirements
- R1: The magnitude of an element is its absolute value as a `W`-bit two's-complement number, reported on `res_mag` (`W-1` bits). The most negative input (for W=16, -32768) saturates to 2^(W-1)-1 (32767).
- R2: The global index of the element in lane `l` of the `b`-th accepted beat of a vector (counting from 0) is `b*LANES + l`. Lane `l` occupies `in_data[l*W +: W]`.
- R3: `res_index` names the element with the largest magnitude among all beats of the vector, and `res_mag` equals that magnitude.
- R4: When several elements share the largest magnitude, the lowest global index wins. This holds within a beat and across beats, including a tie between -32768 and 32767.
- R5: `res_valid` is low in the cycle after the edge that accepts the last beat, and high after the next rising edge.
- R6: Cycles with `in_valid` low are ignored. Their data affects neither the result nor the beat numbering.
- R7: While `res_ready` is low, `res_valid`, `res_index` and `res_mag` hold their values. After an edge with `res_valid` and `res_ready` both high, `res_valid` is low.
- R8: A `start` pulse clears any pending result (`res_valid` low after that edge) and discards the beats accepted so far. The next vector is numbered from beat 0 and is judged only on its own data.
- R9: After reset, `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Abandon the current vector and clear the result |
| in_valid | input | 1 | Beat on `in_data` is present |
| in_last | input | 1 | Present beat is the last of its vector |
| in_data | input | LANES*W | Signed elements, lane 0 in the low bits |
| res_ready | input | 1 | Consumer accepts the result |
| res_valid | output | 1 | Result is available |
| res_index | output | IDXW | Global index of the largest magnitude |
| res_mag | output | W-1 | Magnitude of the winning element |

## Verification
A wrong tie rule or a wrong tree pairing shows up as an index that differs from the reference. This appears in the same result that the bad beat contributes to, one edge after the last beat is registered. A winner register that fails to clear leaks a magnitude from an earlier vector into the next result. The bench exposes this by following a vector that holds a huge value with a vector of small values. A bad beat counter or lane mapping gives an index off by a multiple of `LANES`, or within one beat. Random vectors with inserted idle cycles expose both on the first affected result.

// File: rtl/maxmag_pkg.sv
package maxmag_pkg;
  // A challenger displaces the holder only when strictly larger, so the
  // lower index (held on the left or earlier) survives a tie.
  function automatic logic outranks(input logic [31:0] challenger,
                                    input logic [31:0] holder);
    return challenger > holder;
  endfunction
endpackage

// File: rtl/maxmag_abs.sv
module maxmag_abs #(
  parameter int W = 16
) (
  input  logic [W-1:0] din,
  output logic [W-2:0] mag
);
  function automatic logic [W-2:0] sat_abs(input logic [W-1:0] v);
    logic [W-1:0] neg;
    neg = ~v + 1'b1;
    if (!v[W-1])             return v[W-2:0];
    else if (v[W-2:0] == '0) return '1;
    else                     return neg[W-2:0];
  endfunction

  assign mag = sat_abs(din);
endmodule

// File: rtl/maxmag_tree.sv
module maxmag_tree #(
  parameter int N  = 4,
  parameter int MW = 15,
  parameter int IW = 2
) (
  input  logic [N*MW-1:0] in_mag,
  input  logic [N*IW-1:0] in_idx,
  output logic [MW-1:0]   out_mag,
  output logic [IW-1:0]   out_idx
);
  import maxmag_pkg::*;
  localparam int NODES = 2*N - 1;

  // Heap layout: leaves N-1..2N-2 in lane order; left child is the lower index.
  always_comb begin
    logic [MW-1:0] m [NODES];
    logic [IW-1:0] x [NODES];
    for (int i = 0; i < N; i++) begin
      m[N-1+i] = in_mag[i*MW +: MW];
      x[N-1+i] = in_idx[i*IW +: IW];
    end
    for (int i = N-2; i >= 0; i--) begin
      if (outranks(32'(m[2*i+2]), 32'(m[2*i+1]))) begin
        m[i] = m[2*i+2];
        x[i] = x[2*i+2];
      end else begin
        m[i] = m[2*i+1];
        x[i] = x[2*i+1];
      end
    end
    out_mag = m[0];
    out_idx = x[0];
  end
endmodule

// File: rtl/maxmag_picker.sv
module maxmag_picker #(
  parameter int W      = 16,
  parameter int LANES  = 8,
  parameter int GROUPS = 2,
  parameter int IDXW   = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 in_valid,
  input  logic                 in_last,
  input  logic [LANES*W-1:0]   in_data,
  input  logic                 res_ready,
  output logic                 res_valid,
  output logic [IDXW-1:0]      res_index,
  output logic [W-2:0]         res_mag
);
  import maxmag_pkg::*;
  localparam int MW  = W - 1;
  localparam int LB  = $clog2(LANES);
  localparam int GSZ = LANES / GROUPS;
  localparam int BW  = IDXW - LB;

  // absolute values and lane numbers
  logic [LANES*MW-1:0] lane_mag;
  logic [LANES*LB-1:0] lane_idx;
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    maxmag_abs #(.W(W)) u_abs (.din(in_data[l*W +: W]), .mag(lane_mag[l*MW +: MW]));
    assign lane_idx[l*LB +: LB] = LB'(l);
  end

  // first stage: one pruned tree per group
  logic [GROUPS*MW-1:0] grp_mag;
  logic [GROUPS*LB-1:0] grp_idx;
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    maxmag_tree #(.N(GSZ), .MW(MW), .IW(LB)) u_tree (
      .in_mag (lane_mag[g*GSZ*MW +: GSZ*MW]),
      .in_idx (lane_idx[g*GSZ*LB +: GSZ*LB]),
      .out_mag(grp_mag[g*MW +: MW]),
      .out_idx(grp_idx[g*LB +: LB])
    );
  end

  logic                 beat_take;
  logic [BW-1:0]        beat_cnt;
  logic [GROUPS*MW-1:0] s1_mag;
  logic [GROUPS*LB-1:0] s1_idx;
  logic [BW-1:0]        s1_beat;
  logic                 s1_vld, s1_last;

  assign beat_take = in_valid && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_cnt <= '0;
      s1_vld   <= 1'b0;
      s1_last  <= 1'b0;
      s1_mag   <= '0;
      s1_idx   <= '0;
      s1_beat  <= '0;
    end else begin
      s1_vld  <= beat_take;
      s1_last <= beat_take && in_last;
      if (beat_take) begin
        s1_mag  <= grp_mag;
        s1_idx  <= grp_idx;
        s1_beat <= beat_cnt;
      end
      if (start || (beat_take && in_last)) beat_cnt <= '0;
      else if (beat_take)                  beat_cnt <= beat_cnt + 1'b1;
    end
  end

  // second stage: tree over group winners, then the running winner
  logic [MW-1:0]   bw_mag;
  logic [LB-1:0]   bw_lane;
  logic [IDXW-1:0] bw_idx;
  maxmag_tree #(.N(GROUPS), .MW(MW), .IW(LB)) u_top_tree (
    .in_mag(s1_mag), .in_idx(s1_idx), .out_mag(bw_mag), .out_idx(bw_lane)
  );
  assign bw_idx = {s1_beat, bw_lane};

  logic            best_vld;
  logic [MW-1:0]   best_mag;
  logic [IDXW-1:0] best_idx;
  logic            new_wins, s1_fire, s1_last_fire;
  logic [MW-1:0]   cand_mag;
  logic [IDXW-1:0] cand_idx;

  assign s1_fire      = s1_vld && !start;
  assign s1_last_fire = s1_fire && s1_last;
  assign new_wins     = !best_vld || outranks(32'(bw_mag), 32'(best_mag));
  assign cand_mag     = new_wins ? bw_mag : best_mag;
  assign cand_idx     = new_wins ? bw_idx : best_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_vld  <= 1'b0;
      best_mag  <= '0;
      best_idx  <= '0;
      res_valid <= 1'b0;
      res_index <= '0;
      res_mag   <= '0;
    end else if (start) begin
      best_vld  <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      if (res_valid && res_ready) res_valid <= 1'b0;
      if (s1_fire) begin
        best_vld <= !s1_last;
        best_mag <= cand_mag;
        best_idx <= cand_idx;
        if (s1_last) begin
          res_valid <= 1'b1;
          res_index <= cand_idx;
          res_mag   <= cand_mag;
        end
      end
    end
  end
endmodule

// File: rtl/maxmag_picker_chk.sv
module maxmag_picker_chk #(
  parameter int W    = 16,
  parameter int IDXW = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            res_ready,
  input logic            res_valid,
  input logic [IDXW-1:0] res_index,
  input logic [W-2:0]    res_mag,
  input logic            s1_last_fire,
  input logic            best_vld,
  input logic [W-2:0]    best_mag
);
  // R7
  hold_until_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready && !start && !s1_last_fire |=>
      res_valid && $stable(res_index) && $stable(res_mag));

  // R7
  drop_after_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready && !start && !s1_last_fire |=> !res_valid);

  // R8
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !res_valid && !best_vld);

  // R5
  result_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_last_fire |=> res_valid);

  // R3
  winner_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    best_vld && !start && !s1_last_fire |=> best_mag >= $past(best_mag));
endmodule

bind maxmag_picker maxmag_picker_chk #(.W(W), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .res_ready(res_ready),
  .res_valid(res_valid), .res_index(res_index), .res_mag(res_mag),
  .s1_last_fire(s1_last_fire), .best_vld(best_vld), .best_mag(best_mag)
);

// File: tb/maxmag_picker_bench.sv
module maxmag_picker_bench;
  localparam int W = 16, LANES = 8, GROUPS = 2, IDXW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, in_valid = 1'b0, in_last = 1'b0, res_ready = 1'b0;
  logic [LANES*W-1:0] in_data = '0;
  logic res_valid;
  logic [IDXW-1:0] res_index;
  logic [W-2:0] res_mag;

  always #2 clk = ~clk;

  maxmag_picker #(.W(W), .LANES(LANES), .GROUPS(GROUPS), .IDXW(IDXW)) u_maxmag_picker (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_last(in_last),
    .in_data(in_data), .res_ready(res_ready), .res_valid(res_valid),
    .res_index(res_index), .res_mag(res_mag)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic signed [W-1:0] vec [0:127];

  function automatic int ref_mag(input logic signed [W-1:0] x);
    int v = int'(x);
    if (v < 0) v = -v;
    if (v > 32767) v = 32767;
    return v;
  endfunction

  function automatic int ref_best(input int n);
    int b = 0;
    for (int i = 1; i < n; i++) if (ref_mag(vec[i]) > ref_mag(vec[b])) b = i;
    return b;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1; in_valid = 1'b0;
    @(negedge clk); start = 1'b0;
  endtask

  // sends nb beats from vec; optional idle cycles filled with huge garbage
  task automatic send(input int nb, input bit gaps, input bit with_last);
    for (int b = 0; b < nb; b++) begin
      if (gaps && ($urandom % 2 == 1)) begin
        in_valid = 1'b0; in_last = 1'b1;
        for (int l = 0; l < LANES; l++) in_data[l*W +: W] = 16'h8000;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_last  = with_last && (b == nb - 1);
      for (int l = 0; l < LANES; l++) in_data[l*W +: W] = vec[b*LANES + l];
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic run(input int nb, input bit gaps, input string req);
    int exp_i = ref_best(nb * LANES);
    send(nb, gaps, 1'b1);
    check("R5 low one cycle after last", int'(res_valid), 0);
    @(negedge clk);
    check("R5 valid after second edge", int'(res_valid), 1);
    check({req, " index"}, int'(res_index), exp_i);
    check({req, " mag R1"}, int'(res_mag), ref_mag(vec[exp_i]));
    repeat ($urandom % 3) begin
      @(negedge clk);
      check("R7 held index", int'(res_index), exp_i);
      check("R7 held valid", int'(res_valid), 1);
    end
    res_ready = 1'b1;
    @(negedge clk); res_ready = 1'b0;
    check("R7 dropped after accept", int'(res_valid), 0);
  endtask

  task automatic fill_rand(input int n);
    for (int i = 0; i < n; i++) vec[i] = W'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R9 reset valid", int'(res_valid), 0);
    rst_n = 1'b1;
    pulse_start();

    // R3 R2 random vectors, with and without gaps (R6)
    for (int t = 0; t < 20; t++) begin
      int nb = 1 + ($urandom % 6);
      fill_rand(nb * LANES);
      run(nb, t[0], "R3 random");
    end

    // R4 all equal
    for (int i = 0; i < 24; i++) vec[i] = 16'sd500;
    run(3, 0, "R4 all equal");
    // R4 saturated tie: -32768 at 13 vs 32767 at 5
    for (int i = 0; i < 16; i++) vec[i] = 16'sd7;
    vec[13] = 16'sh8000; vec[5] = 16'sh7fff;
    run(2, 0, "R4 saturated tie");
    // R1 negative-only winner
    for (int i = 0; i < 16; i++) vec[i] = -16'sd3;
    vec[9] = 16'sh8000;
    run(2, 1, "R1 saturate");
    // R2 maximum in final lane of final beat
    for (int i = 0; i < 40; i++) vec[i] = 16'sd100;
    vec[39] = -16'sd101;
    run(5, 0, "R2 last lane");
    // R4 all zero
    for (int i = 0; i < 8; i++) vec[i] = '0;
    run(1, 0, "R4 zeros");

    // R8 abandoned partial vector then a small one
    for (int i = 0; i < 16; i++) vec[i] = 16'sh7000;
    send(2, 0, 1'b0);
    pulse_start();
    for (int i = 0; i < 16; i++) vec[i] = 16'(i);
    run(2, 0, "R8 after start");

    // R8 start clears pending result
    fill_rand(8);
    send(1, 0, 1'b1);
    @(negedge clk);
    check("R8 pending before start", int'(res_valid), 1);
    pulse_start();
    check("R8 start cleared result", int'(res_valid), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule